// File: doc/BRIEF.md
# SPI FIFO Status and Receive Filter

This block sits between a serial shift engine and a host register bus. It buffers outgoing bytes in a transmit queue and incoming bytes in a receive queue. Alongside the queues it keeps a small status byte and a masked interrupt line. The host pushes transmit bytes through a write strobe and pulls receive bytes through a read strobe. The serial engine takes transmit bytes with a pop strobe and delivers received bytes with a receive strobe.

Each queue holds 16 bytes. The two overflow flags are sticky: an overflowing byte is dropped, the queue keeps its contents, and the flag stays set until the host reads the status byte. The two empty flags follow queue occupancy live. A receive threshold flag rises once the receive occupancy is at least a programmable 4-bit level. A level of zero turns that flag off. A compare filter can discard any received byte that equals a programmable dump value, so that byte never reaches the receive queue. Four enables select which status conditions drive the registered interrupt output.

Top module: `spi_fifo_hub`

## Requirements
- R1: Out of reset both queues are empty, statusByte reads 0x0C (bits 2 and 3 set), irq is 0, engTxValid is 0, and statusByte bits 7:5 always read 0.
- R2: Transmit bytes reach engTxData in the order they were written. engTxData shows the oldest byte while engTxValid is 1, and engTxPop advances the queue.
- R3: A byte received while the receive queue holds 16 bytes and not removed by the filter is dropped, the 16 stored bytes are kept, and statusByte bit 0 becomes 1.
- R4: A host write while the transmit queue holds 16 bytes is dropped, the 16 stored bytes are kept, and statusByte bit 1 becomes 1.
- R5: statusByte bit 2 is 1 exactly when the receive queue is empty. Bit 3 is 1 exactly when the transmit queue is empty.
- R6: statusByte bit 4 is 1 when rxThreshold is nonzero and the receive occupancy is greater than or equal to rxThreshold. It is always 0 when rxThreshold is 0.
- R7: When dumpEnable is 1, a received byte equal to dumpValue is not stored. When dumpEnable is 0, the same byte is stored.
- R8: A byte removed by the filter does not set statusByte bit 0, even when the receive queue is full.
- R9: Overflow flags stay set until a cycle with statusRead high. statusByte shows the flags during that cycle, and they read 0 on the next cycle unless a new overflow occurs in the read cycle.
- R10: irq is registered. It is 1 in the cycle after any statusByte bit in {0,1,3,4} is 1 together with the same bit of irqEnable, and 0 otherwise.
- R11: irqEnable bit 2 and bits 7:5 have no effect on irq.
- R12: Received bytes appear on hostRxData in arrival order, and hostRxRead removes the oldest byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostTxWrite | input | 1 | Host write strobe for transmit data |
| hostTxData | input | 8 | Transmit byte from the host |
| engTxPop | input | 1 | Engine takes the oldest transmit byte |
| engTxData | output | 8 | Oldest transmit byte |
| engTxValid | output | 1 | Transmit queue not empty |
| engRxStrobe | input | 1 | Engine delivers a received byte |
| engRxData | input | 8 | Received byte |
| hostRxRead | input | 1 | Host removes the oldest received byte |
| hostRxData | output | 8 | Oldest received byte |
| statusRead | input | 1 | Host status read; clears the sticky flags |
| statusByte | output | 8 | Status: 0 rx overflow, 1 tx overflow, 2 rx empty, 3 tx empty, 4 rx threshold |
| rxThreshold | input | 4 | Receive threshold level; 0 disables |
| dumpEnable | input | 1 | Enables the dump-byte filter |
| dumpValue | input | 8 | Byte value the filter discards |
| irqEnable | input | 8 | Interrupt enables in status bit positions 0,1,3,4 |
| irq | output | 1 | Registered interrupt |

## Verification
Every queue write, pop and overflow takes effect at the clock edge where the strobe is seen. statusByte, engTxData and hostRxData therefore show the result at the falling edge that follows, and the bench compares them there. irq goes through one more register, so the bench first checks that it has not yet moved at the falling edge after a condition appears, and then checks the new level one full cycle later. Expected queue contents come from a scoreboard that applies the filter and overflow rules as bytes are driven. A monitor compares each popped byte in the cycle its pop strobe is high, before the edge that removes it.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;
  // status byte bit positions
  localparam int ST_RX_OVF = 0;
  localparam int ST_TX_OVF = 1;
  localparam int ST_RX_EMP = 2;
  localparam int ST_TX_EMP = 3;
  localparam int ST_RX_THR = 4;

  // status bits that have an interrupt enable
  localparam logic [7:0] IRQ_SOURCES = 8'h1B;

  // strobes from control to datapath
  typedef struct packed {
    logic txPush;
    logic txPop;
    logic rxPush;
    logic rxPop;
  } fifoCtl_t;
endpackage

// File: rtl/spi_fifo_ring.sv
module spi_fifo_ring #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] headData,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= nextPtr(wrPtr);
      if (pop)  rdPtr <= nextPtr(rdPtr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign headData = mem[rdPtr];
  assign full     = (count == CNT_W'(DEPTH));
  assign empty    = (count == '0);
endmodule

// File: rtl/spi_fifo_dp.sv
module spi_fifo_dp
  import spi_fifo_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoCtl_t          ctl,
  input  logic [DATA_W-1:0] hostTxData,
  input  logic [DATA_W-1:0] engRxData,
  output logic [DATA_W-1:0] engTxData,
  output logic [DATA_W-1:0] hostRxData,
  output logic [CNT_W-1:0]  txCount,
  output logic [CNT_W-1:0]  rxCount,
  output logic              txFull,
  output logic              txEmpty,
  output logic              rxFull,
  output logic              rxEmpty
);
  spi_fifo_ring #(.WIDTH(DATA_W), .DEPTH(DEPTH)) txRing (
    .clk(clk), .rstN(rstN),
    .push(ctl.txPush), .pushData(hostTxData), .pop(ctl.txPop),
    .headData(engTxData), .count(txCount), .full(txFull), .empty(txEmpty)
  );

  spi_fifo_ring #(.WIDTH(DATA_W), .DEPTH(DEPTH)) rxRing (
    .clk(clk), .rstN(rstN),
    .push(ctl.rxPush), .pushData(engRxData), .pop(ctl.rxPop),
    .headData(hostRxData), .count(rxCount), .full(rxFull), .empty(rxEmpty)
  );
endmodule

// File: rtl/spi_fifo_ctl.sv
module spi_fifo_ctl
  import spi_fifo_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int THR_W  = 4,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostTxWrite,
  input  logic              engTxPop,
  input  logic              engRxStrobe,
  input  logic [DATA_W-1:0] engRxData,
  input  logic              hostRxRead,
  input  logic              statusRead,
  input  logic [THR_W-1:0]  rxThreshold,
  input  logic              dumpEnable,
  input  logic [DATA_W-1:0] dumpValue,
  input  logic [7:0]        irqEnable,
  input  logic              txFull,
  input  logic              txEmpty,
  input  logic              rxFull,
  input  logic              rxEmpty,
  input  logic [CNT_W-1:0]  rxCount,
  output fifoCtl_t          ctl,
  output logic [7:0]        statusByte,
  output logic              irq
);
  logic rxMatch, rxKeep, txOvfSet, rxOvfSet;
  logic txOvf, rxOvf, thrHit;

  assign rxMatch  = dumpEnable && (engRxData == dumpValue);
  assign rxKeep   = engRxStrobe && !rxMatch;
  assign txOvfSet = hostTxWrite && txFull;
  assign rxOvfSet = rxKeep && rxFull;

  always_comb begin
    ctl.txPush = hostTxWrite && !txFull;
    ctl.txPop  = engTxPop && !txEmpty;
    ctl.rxPush = rxKeep && !rxFull;
    ctl.rxPop  = hostRxRead && !rxEmpty;
  end

  // sticky overflow flags; a new overflow wins over a clearing read
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txOvf <= 1'b0;
      rxOvf <= 1'b0;
    end else begin
      if (txOvfSet)        txOvf <= 1'b1;
      else if (statusRead) txOvf <= 1'b0;
      if (rxOvfSet)        rxOvf <= 1'b1;
      else if (statusRead) rxOvf <= 1'b0;
    end
  end

  assign thrHit = (rxThreshold != '0) && (rxCount >= CNT_W'(rxThreshold));

  always_comb begin
    statusByte            = '0;
    statusByte[ST_RX_OVF] = rxOvf;
    statusByte[ST_TX_OVF] = txOvf;
    statusByte[ST_RX_EMP] = rxEmpty;
    statusByte[ST_TX_EMP] = txEmpty;
    statusByte[ST_RX_THR] = thrHit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) irq <= 1'b0;
    else       irq <= |(statusByte & irqEnable & IRQ_SOURCES);
  end
endmodule

// File: rtl/spi_fifo_hub.sv
module spi_fifo_hub
  import spi_fifo_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  parameter int THR_W  = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostTxWrite,
  input  logic [DATA_W-1:0] hostTxData,
  input  logic              engTxPop,
  output logic [DATA_W-1:0] engTxData,
  output logic              engTxValid,
  input  logic              engRxStrobe,
  input  logic [DATA_W-1:0] engRxData,
  input  logic              hostRxRead,
  output logic [DATA_W-1:0] hostRxData,
  input  logic              statusRead,
  output logic [7:0]        statusByte,
  input  logic [THR_W-1:0]  rxThreshold,
  input  logic              dumpEnable,
  input  logic [DATA_W-1:0] dumpValue,
  input  logic [7:0]        irqEnable,
  output logic              irq
);
  fifoCtl_t         ctl;
  logic [CNT_W-1:0] txCount, rxCount;
  logic             txFull, txEmpty, rxFull, rxEmpty;

  spi_fifo_ctl #(.DATA_W(DATA_W), .THR_W(THR_W), .CNT_W(CNT_W)) ctlUnit (
    .clk(clk), .rstN(rstN),
    .hostTxWrite(hostTxWrite), .engTxPop(engTxPop),
    .engRxStrobe(engRxStrobe), .engRxData(engRxData),
    .hostRxRead(hostRxRead), .statusRead(statusRead),
    .rxThreshold(rxThreshold), .dumpEnable(dumpEnable),
    .dumpValue(dumpValue), .irqEnable(irqEnable),
    .txFull(txFull), .txEmpty(txEmpty), .rxFull(rxFull), .rxEmpty(rxEmpty),
    .rxCount(rxCount), .ctl(ctl), .statusByte(statusByte), .irq(irq)
  );

  spi_fifo_dp #(.DATA_W(DATA_W), .DEPTH(DEPTH)) dpUnit (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .hostTxData(hostTxData), .engRxData(engRxData),
    .engTxData(engTxData), .hostRxData(hostRxData),
    .txCount(txCount), .rxCount(rxCount),
    .txFull(txFull), .txEmpty(txEmpty), .rxFull(rxFull), .rxEmpty(rxEmpty)
  );

  assign engTxValid = !txEmpty;
endmodule

// File: rtl/spi_fifo_hub_chk.sv
module spi_fifo_hub_chk #(
  parameter int DATA_W = 8,
  parameter int THR_W  = 4,
  parameter int CNT_W  = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              hostTxWrite,
  input logic              engTxPop,
  input logic              engRxStrobe,
  input logic [DATA_W-1:0] engRxData,
  input logic              hostRxRead,
  input logic              statusRead,
  input logic [7:0]        statusByte,
  input logic [THR_W-1:0]  rxThreshold,
  input logic              dumpEnable,
  input logic [DATA_W-1:0] dumpValue,
  input logic [7:0]        irqEnable,
  input logic              irq,
  input logic [CNT_W-1:0]  txCount,
  input logic [CNT_W-1:0]  rxCount,
  input logic              txFull,
  input logic              rxFull
);
  assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (!rstN)
    statusByte[7:5] == 3'b000);

  assert_rx_overflow_R3: assert property (@(posedge clk) disable iff (!rstN)
    (engRxStrobe && rxFull && !hostRxRead && !(dumpEnable && engRxData == dumpValue))
      |=> (statusByte[0] && rxCount == $past(rxCount)));

  assert_tx_overflow_R4: assert property (@(posedge clk) disable iff (!rstN)
    (hostTxWrite && txFull && !engTxPop) |=> (statusByte[1] && txCount == $past(txCount)));

  assert_threshold_off_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rxThreshold == '0) |-> !statusByte[4]);

  assert_filter_drop_R7: assert property (@(posedge clk) disable iff (!rstN)
    (engRxStrobe && dumpEnable && engRxData == dumpValue && !hostRxRead)
      |=> rxCount == $past(rxCount));

  assert_sticky_rx_R9: assert property (@(posedge clk) disable iff (!rstN)
    (statusByte[0] && !statusRead) |=> statusByte[0]);

  assert_sticky_tx_R9: assert property (@(posedge clk) disable iff (!rstN)
    (statusByte[1] && !statusRead) |=> statusByte[1]);

  assert_irq_rise_R10: assert property (@(posedge clk) disable iff (!rstN)
    (|(statusByte & irqEnable & 8'h1B)) |=> irq);

  assert_irq_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    !(|(statusByte & irqEnable & 8'h1B)) |=> !irq);
endmodule

bind spi_fifo_hub spi_fifo_hub_chk #(.DATA_W(DATA_W), .THR_W(THR_W), .CNT_W(CNT_W)) chk (
  .clk(clk), .rstN(rstN), .hostTxWrite(hostTxWrite), .engTxPop(engTxPop),
  .engRxStrobe(engRxStrobe), .engRxData(engRxData), .hostRxRead(hostRxRead),
  .statusRead(statusRead), .statusByte(statusByte), .rxThreshold(rxThreshold),
  .dumpEnable(dumpEnable), .dumpValue(dumpValue), .irqEnable(irqEnable),
  .irq(irq), .txCount(txCount), .rxCount(rxCount), .txFull(txFull), .rxFull(rxFull)
);

// File: tb/spi_fifo_hub_test.sv
`timescale 1ns/1ps
module spi_fifo_hub_test;
  localparam int DEPTH = 16;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       hostTxWrite = 1'b0, engTxPop = 1'b0, engRxStrobe = 1'b0;
  logic       hostRxRead = 1'b0, statusRead = 1'b0, dumpEnable = 1'b0;
  logic [7:0] hostTxData = '0, engRxData = '0, dumpValue = '0, irqEnable = '0;
  logic [3:0] rxThreshold = '0;
  logic [7:0] engTxData, hostRxData, statusByte;
  logic       engTxValid, irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // scoreboard queues and model flags
  logic [7:0] txExp[$];
  logic [7:0] rxExp[$];
  bit txOvfM = 0, rxOvfM = 0;

  always #4 clk = ~clk;

  spi_fifo_hub uut (
    .clk(clk), .rstN(rstN), .hostTxWrite(hostTxWrite), .hostTxData(hostTxData),
    .engTxPop(engTxPop), .engTxData(engTxData), .engTxValid(engTxValid),
    .engRxStrobe(engRxStrobe), .engRxData(engRxData), .hostRxRead(hostRxRead),
    .hostRxData(hostRxData), .statusRead(statusRead), .statusByte(statusByte),
    .rxThreshold(rxThreshold), .dumpEnable(dumpEnable), .dumpValue(dumpValue),
    .irqEnable(irqEnable), .irq(irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] modelStatus();
    logic thr = (rxThreshold != 0) && (rxExp.size() >= int'(rxThreshold));
    return {3'b000, thr, txExp.size() == 0, rxExp.size() == 0, txOvfM, rxOvfM};
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // drivers: update the expected model, then drive one cycle
  task automatic hostWrite(input logic [7:0] b);
    if (txExp.size() < DEPTH) txExp.push_back(b);
    else txOvfM = 1;
    hostTxWrite = 1; hostTxData = b;
    tick();
    hostTxWrite = 0;
  endtask

  task automatic engReceive(input logic [7:0] b);
    if (!(dumpEnable && b == dumpValue)) begin
      if (rxExp.size() < DEPTH) rxExp.push_back(b);
      else rxOvfM = 1;
    end
    engRxStrobe = 1; engRxData = b;
    tick();
    engRxStrobe = 0;
  endtask

  task automatic hostRead();
    hostRxRead = 1;
    tick();
    hostRxRead = 0;
  endtask

  task automatic engPop();
    engTxPop = 1;
    tick();
    engTxPop = 0;
  endtask

  task automatic readStatus(input string req);
    check(req, statusByte, modelStatus());
    statusRead = 1;
    tick();
    statusRead = 0;
    txOvfM = 0; rxOvfM = 0;
  endtask

  // monitor: compares each popped byte before the edge that removes it
  always begin
    @(negedge clk);
    #1;
    if (rstN && hostRxRead) begin
      if (rxExp.size() == 0) check("R12 unexpected read", hostRxData, 8'hxx);
      else check("R12 rx order", hostRxData, rxExp.pop_front());
    end
    if (rstN && engTxPop) begin
      if (txExp.size() == 0) check("R2 unexpected pop", engTxData, 8'hxx);
      else check("R2 tx order", engTxData, txExp.pop_front());
    end
  end

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R1 reset state
    check("R1 status after reset", statusByte, 8'h0C);
    check("R1 irq after reset", {7'b0, irq}, 8'h00);
    check("R1 tx valid after reset", {7'b0, engTxValid}, 8'h00);

    // R2 / R5 small transmit burst
    hostWrite(8'h31); hostWrite(8'h32); hostWrite(8'h33);
    check("R5 tx not empty", statusByte, modelStatus());
    check("R2 tx valid", {7'b0, engTxValid}, 8'h01);
    repeat (3) engPop();
    check("R5 tx empty again", statusByte, 8'h0C);

    // R4 transmit overflow keeps contents
    for (int i = 0; i < DEPTH; i++) hostWrite(8'h40 + 8'(i));
    check("R4 full no flag", statusByte, 8'h04);
    hostWrite(8'hEE);
    check("R4 tx overflow flag", statusByte, 8'h06);
    tick();
    check("R9 tx flag sticky", statusByte, 8'h06);
    readStatus("R9 status read shows flag");
    check("R9 flag cleared", statusByte, 8'h04);
    repeat (DEPTH) engPop();
    check("R4 contents intact then empty", statusByte, 8'h0C);

    // R6 threshold
    rxThreshold = 4'd3;
    engReceive(8'h51); engReceive(8'h52);
    check("R6 below threshold", statusByte, 8'h08);
    engReceive(8'h53);
    check("R6 at threshold", statusByte, 8'h18);
    rxThreshold = 4'd0;
    engReceive(8'h54); engReceive(8'h55);
    check("R6 threshold zero disables", statusByte, 8'h08);
    repeat (5) hostRead();
    check("R5 rx empty after drain", statusByte, 8'h0C);

    // R7 filter
    dumpEnable = 1; dumpValue = 8'hA5;
    engReceive(8'h11); engReceive(8'hA5); engReceive(8'h22);
    check("R7 filtered byte absent", statusByte, modelStatus());
    hostRead(); hostRead();
    check("R7 only two bytes stored", statusByte, 8'h0C);
    dumpEnable = 0;
    engReceive(8'hA5);
    check("R7 compare off stores byte", hostRxData, 8'hA5);
    hostRead();

    // R8 / R3 receive overflow with filter
    dumpEnable = 1;
    for (int i = 0; i < DEPTH; i++) engReceive(8'h60 + 8'(i));
    engReceive(8'hA5);
    check("R8 filtered byte no overflow", statusByte, 8'h08);
    engReceive(8'h99);
    check("R3 rx overflow flag", statusByte, 8'h09);

    // R10 / R11 interrupt latency and masking
    irqEnable = 8'h01;
    check("R10 irq not yet", {7'b0, irq}, 8'h00);
    tick();
    check("R10 irq one cycle later", {7'b0, irq}, 8'h01);
    readStatus("R9 rx flag visible in read");
    check("R10 irq still high in clear cycle", {7'b0, irq}, 8'h01);
    tick();
    check("R10 irq drops after clear", {7'b0, irq}, 8'h00);
    repeat (DEPTH) hostRead();
    irqEnable = 8'hE4;
    tick(); tick();
    check("R11 reserved enables ignored", {7'b0, irq}, 8'h00);
    irqEnable = 8'h08;
    tick(); tick();
    check("R10 tx empty interrupt", {7'b0, irq}, 8'h01);
    irqEnable = 8'h00;
    rxThreshold = 4'd2;
    engReceive(8'h71); engReceive(8'h72);
    irqEnable = 8'h10;
    tick(); tick();
    check("R10 threshold interrupt", {7'b0, irq}, 8'h01);
    check("R12 rx head", hostRxData, 8'h71);
    hostRead(); hostRead();
    check("R1 final status", statusByte, 8'h0C);

    finishRun();
  end
endmodule